// File: doc/BRIEF.md
# Subclock Watch Timer

This block is a free-running 15-bit up counter driven directly by the 32 kHz subclock. Because it runs from the subclock alone, it takes no notice of which system clock source is selected or of any system clock divider. Firmware uses it in two ways. One is to time how long a newly started subclock oscillator needs to settle before the system clock is moved onto it. The other is to get periodic work done at a fixed subclock rate. A selectable tap on the counter raises a watch interrupt flag at the end of each chosen interval.

The counter advances only while the oscillator reports that it is running. It also freezes in stop mode, but only when the stop-mode oscillator-disable bit is set. When that bit is clear, the counter keeps counting through stop mode. Software can force the count to zero with a clear request. The clear request and the interrupt enable come from the register clock domain, so each is passed through a two-flop synchronizer into the subclock domain.

Top module: `watch_timer`

## Requirements
- R1: While `rst` is high at a `clk_sub` edge, `count` becomes 0, `irq_flag` becomes 0 and `irq_req` becomes 0.
- R2: On each `clk_sub` edge where the count advances, `count` increases by one. After 0x7FFF it wraps to 0.
- R3: While `osc_run` is low, `count` holds its value.
- R4: While `stop_mode` and `osc_off_in_stop` are both high, `count` holds its value. While `stop_mode` is high and `osc_off_in_stop` is low, `count` keeps advancing.
- R5: `clr_req` passes through two synchronizer flops. A level raised before edge k makes `count` read 0 after edge k+2, and `count` stays 0 while the level is held. Clearing takes priority over advancing.
- R6: `tap_sel` value n (0 to 3) selects an interval of 2^(12+n) subclock cycles. `irq_flag` sets on the edge where an advance makes count bit 11+n fall from 1 to 0, which means the count reaches a multiple of 2^(12+n). A clear never sets the flag.
- R7: `irq_flag` stays set until an edge where `irq_ack` is high, and that edge clears it. If a set and an acknowledge fall on the same edge, the flag stays set.
- R8: `irq_req` equals `irq_flag` AND the synchronized `int_en`. A change on `int_en` reaches `irq_req` after two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sub | input | 1 | 32 kHz subclock |
| rst | input | 1 | Synchronous active-high reset |
| osc_run | input | 1 | Subclock oscillator is running |
| stop_mode | input | 1 | Device is in stop mode |
| osc_off_in_stop | input | 1 | Stop mode shuts the subclock off |
| clr_req | input | 1 | Asynchronous software clear level |
| int_en | input | 1 | Asynchronous watch interrupt enable |
| irq_ack | input | 1 | Write-one clear of the flag (subclock domain) |
| tap_sel | input | 2 | Interval select, 2^(12+n) cycles |
| count | output | 15 | Current counter value |
| irq_flag | output | 1 | Watch interrupt flag |
| irq_req | output | 1 | Enabled interrupt request |

## Verification
A wrong internal count shows up on `count` on the very next subclock edge. A wrong flag decision, however, can stay hidden for as long as 32768 edges, until the selected tap is crossed. For that reason the interval for every tap is run all the way to its boundary, including a full wrap of the counter. Synchronizer depth errors appear as a one-cycle shift in when a clear or an enable change takes effect, so both are sampled exactly on the predicted edge.

// File: rtl/wt_pkg.sv
package wt_pkg;
    localparam int CNT_W    = 15;
    localparam int TAP_BASE = 12;
    localparam int SEL_W    = 2;
    localparam int SYNC_N   = 2;

    typedef enum logic [SEL_W-1:0] {
        TAP_4K  = 2'd0,
        TAP_8K  = 2'd1,
        TAP_16K = 2'd2,
        TAP_32K = 2'd3
    } tap_sel_e;

    // software controls after the domain crossing
    typedef struct packed {
        logic clr;
        logic en;
    } sw_ctl_t;

    // ones on all bits at and below the selected tap bit
    function automatic logic [31:0] tap_mask(input int base, input logic [SEL_W-1:0] sel);
        logic [31:0] one;
        one = 32'd1;
        return (one << (base + int'(sel))) - 32'd1;
    endfunction
endpackage

// File: rtl/wt_sync.sv
module wt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/wt_counter.sv
module wt_counter
    import wt_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int BASE = TAP_BASE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             clr,
    input  tap_sel_e         sel,
    output logic [CW-1:0]    cnt_q,
    output logic             tap_fall
);
    logic [CW-1:0] mask;
    logic [31:0]   mask_w;

    always_comb begin
        mask_w   = tap_mask(BASE, sel);
        mask     = mask_w[CW-1:0];
        tap_fall = adv && !clr && ((cnt_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (adv) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wt_irq.sv
module wt_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    input  logic en,
    output logic flag,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (ack) flag <= 1'b0;
    end

    assign req = flag & en;
endmodule

// File: rtl/watch_timer.sv
module watch_timer
    import wt_pkg::*;
#(
    parameter int CNT_WIDTH = CNT_W,
    parameter int TAP_LOW   = TAP_BASE,
    parameter int SYNC_LEN  = SYNC_N
) (
    input  logic                 clk_sub,
    input  logic                 rst,
    input  logic                 osc_run,
    input  logic                 stop_mode,
    input  logic                 osc_off_in_stop,
    input  logic                 clr_req,
    input  logic                 int_en,
    input  logic                 irq_ack,
    input  logic [SEL_W-1:0]     tap_sel,
    output logic [CNT_WIDTH-1:0] count,
    output logic                 irq_flag,
    output logic                 irq_req
);
    localparam int CTL_W = $bits(sw_ctl_t);

    sw_ctl_t ctl_raw, ctl_s;
    logic    clr_s;
    logic    advance;
    logic    tap_fall;

    assign ctl_raw = '{clr: clr_req, en: int_en};
    assign clr_s   = ctl_s.clr;
    assign advance = osc_run && !(stop_mode && osc_off_in_stop);

    wt_sync #(.W(CTL_W), .STAGES(SYNC_LEN)) u_sync (
        .clk (clk_sub),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    wt_counter #(.CW(CNT_WIDTH), .BASE(TAP_LOW)) u_cnt (
        .clk      (clk_sub),
        .rst      (rst),
        .adv      (advance),
        .clr      (clr_s),
        .sel      (tap_sel_e'(tap_sel)),
        .cnt_q    (count),
        .tap_fall (tap_fall)
    );

    wt_irq u_irq (
        .clk  (clk_sub),
        .rst  (rst),
        .set  (tap_fall),
        .ack  (irq_ack),
        .en   (ctl_s.en),
        .flag (irq_flag),
        .req  (irq_req)
    );
endmodule

// File: rtl/wt_chk.sv
module wt_chk #(
    parameter int CW   = 15,
    parameter int BASE = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          osc_run,
    input logic          stop_mode,
    input logic          osc_off_in_stop,
    input logic          clr_s,
    input logic          irq_ack,
    input logic [CW-1:0] count,
    input logic          irq_flag
);
    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (osc_run && !(stop_mode && osc_off_in_stop) && !clr_s) |=> count == CW'($past(count) + 1'b1));

    // R3
    halt_no_osc_chk: assert property (@(posedge clk) disable iff (rst)
        (!osc_run && !clr_s) |=> $stable(count));

    // R4
    halt_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && osc_off_in_stop && !clr_s) |=> $stable(count));

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_s |=> count == '0);

    // R6
    flag_on_tap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> count[BASE-1:0] == '0);

    // R7
    flag_drop_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_flag) |-> $past(irq_ack));
endmodule

bind watch_timer wt_chk #(.CW(CNT_WIDTH), .BASE(TAP_LOW)) u_chk (
    .clk             (clk_sub),
    .rst             (rst),
    .osc_run         (osc_run),
    .stop_mode       (stop_mode),
    .osc_off_in_stop (osc_off_in_stop),
    .clr_s           (clr_s),
    .irq_ack         (irq_ack),
    .count           (count),
    .irq_flag        (irq_flag)
);

// File: tb/sim_watch_timer.sv
`timescale 1ns/1ps
module sim_watch_timer;
    logic        clk = 1'b0;
    logic        rst, run, stp, off, clr, en, ack;
    logic [1:0]  sel;
    logic [14:0] count;
    logic        flag, req;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    watch_timer u0 (
        .clk_sub(clk), .rst(rst), .osc_run(run), .stop_mode(stp),
        .osc_off_in_stop(off), .clr_req(clr), .int_en(en), .irq_ack(ack),
        .tap_sel(sel), .count(count), .irq_flag(flag), .irq_req(req)
    );

    // reference model built from the requirements
    logic [14:0] m_cnt;
    logic        m_flag, c1, c2, e1, e2;

    function automatic logic [14:0] mask_of(input logic [1:0] s);
        logic [31:0] m;
        m = (32'd1 << (12 + int'(s))) - 32'd1;
        return m[14:0];
    endfunction

    always @(posedge clk) begin
        logic a, s;
        if (rst) begin
            m_cnt = '0; m_flag = 0; c1 = 0; c2 = 0; e1 = 0; e2 = 0;
        end else begin
            a = run && !(stp && off);
            s = a && !c2 && ((m_cnt & mask_of(sel)) == mask_of(sel));
            if (c2) m_cnt = '0;
            else if (a) m_cnt = m_cnt + 1'b1;
            if (s) m_flag = 1'b1;
            else if (ack) m_flag = 1'b0;
            c2 = c1; c1 = clr; e2 = e1; e1 = en;
        end
    end

    task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk(count == m_cnt, "R2", 32'(count), 32'(m_cnt));
        chk(flag == m_flag, "R6", 32'(flag), 32'(m_flag));
        chk(req == (m_flag && e2), "R8", 32'(req), 32'(m_flag && e2));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [14:0] rec;
        void'($urandom(32'h5EED1234));
        rst = 1; run = 1; stp = 0; off = 0; clr = 0; en = 1; ack = 0; sel = 2'd0;
        @(negedge clk);
        repeat (3) step();
        // R1 reset state
        chk(count == 0, "R1", 32'(count), 0);
        chk(flag == 0, "R1", 32'(flag), 0);
        chk(req == 0, "R1", 32'(req), 0);
        rst = 0;

        // R6 4096-cycle tap
        repeat (4095) step();
        chk(count == 15'd4095, "R2", 32'(count), 4095);
        chk(flag == 0, "R6", 32'(flag), 0);
        step();
        chk(flag == 1, "R6", 32'(flag), 1);
        chk(req == 1, "R8", 32'(req), 1);

        // R8 enable through two stages
        en = 0;
        step();
        chk(req == 1, "R8", 32'(req), 1);
        step();
        chk(req == 0, "R8", 32'(req), 0);
        en = 1;
        repeat (2) step();

        // R7 acknowledge
        ack = 1; step(); ack = 0;
        chk(flag == 0, "R7", 32'(flag), 0);

        // R3 oscillator not running
        run = 0; rec = count;
        repeat (20) step();
        chk(count == rec, "R3", 32'(count), 32'(rec));
        run = 1;

        // R4 stop mode with and without oscillator shutdown
        stp = 1; off = 1; rec = count;
        repeat (20) step();
        chk(count == rec, "R4", 32'(count), 32'(rec));
        off = 0;
        repeat (20) step();
        chk(count == rec + 15'd20, "R4", 32'(count), 32'(rec + 15'd20));
        stp = 0;

        // R5 clear latency and hold
        clr = 1; rec = count;
        repeat (2) step();
        chk(count == rec + 15'd2, "R5", 32'(count), 32'(rec + 15'd2));
        step();
        chk(count == 0, "R5", 32'(count), 0);
        repeat (5) step();
        chk(count == 0, "R5", 32'(count), 0);
        chk(flag == 0, "R6", 32'(flag), 0);
        clr = 0;

        // R7 set wins over a simultaneous acknowledge
        ack = 1;
        for (int i = 0; i < 5000 && count != 15'd4096; i++) step();
        chk(flag == 1, "R7", 32'(flag), 1);
        step();
        chk(flag == 0, "R7", 32'(flag), 0);
        ack = 0;

        // R2 / R6 full wrap with the 32768 tap
        sel = 2'd3; clr = 1;
        repeat (3) step();
        clr = 0;
        for (int i = 0; i < 33000 && count != 15'h7FFF; i++) step();
        chk(flag == 0, "R6", 32'(flag), 0);
        step();
        chk(count == 0, "R2", 32'(count), 0);
        chk(flag == 1, "R6", 32'(flag), 1);

        // constrained random mix
        for (int i = 0; i < 50000; i++) begin
            run = ($urandom % 64) != 0;
            if ($urandom % 200 == 0) stp = ~stp;
            if ($urandom % 100 == 0) off = ~off;
            clr = ($urandom % 3000) == 0;
            if ($urandom % 8000 == 0) sel = 2'($urandom % 4);
            ack = ($urandom % 700) == 0;
            if ($urandom % 300 == 0) en = ~en;
            step();
        end
        finish_run();
    end
endmodule